// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file behind one eight-pin general-purpose I/O port. A processor reaches it over an APB slave interface and uses it to pick a 4-bit function code for each pin, to hold the value that output pins drive, to turn the pull-up, pull-down and input-path enables of each pad on or off, and to read the pad values back. The function multiplexer and the pad cells lie outside this block. They take the per-pin codes, the output values and the pad enables from its output pins.

Software can change output pins with a single write to the atomic control word, so it needs no read-modify-write. Each bit of the low byte sets a pin and each bit of the next byte clears it. When a pin has both bits set, its output toggles. These actions affect only pins whose function code is plain output. No pin can have both pulls enabled: the most recent write wins, and the opposite enable for that pin is cleared. APB accesses complete in the access phase with no wait states. The bus has no back-pressure, because `pready` is held high.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every function code, the output register, both pull enables and the input enables are 0. As a result, `pin_oe` is 0 and every pin is a GPIO input.
- R2: The word at offset 0x00 holds the function codes. Pin i uses bits [4i+3:4i]. The word reads back as written and appears on `pin_func`.
- R3: `pin_oe[i]` is 1 exactly when pin i has code 4'b0001 (GPIO output). Code 4'b0000 is GPIO input, and codes 4'b0010 to 4'b1111 select alternate functions. For codes other than 4'b0001, `pin_oe[i]` is 0.
- R4: A write to offset 0x04 loads bits [7:0] into the output register. `pin_out` shows the new value from the cycle after the access phase.
- R5: A read of offset 0x04 returns, for each pin, the output register bit if the pin has code 4'b0001. For any other pin it returns `pin_in[i]` gated by that pin's input enable, so it reads 0 while the enable is off.
- R6: A write to offset 0x08 carries set bits in [7:0] and clear bits in [15:8]. A set bit alone drives that pin's output to 1, and a clear bit alone drives it to 0.
- R7: In a write to offset 0x08, a pin with both its set and clear bits at 1 has its output inverted. A pin with both bits at 0 keeps its value.
- R8: Set, clear and toggle leave the output register bit of any pin without code 4'b0001 unchanged.
- R9: Offset 0x0C holds the pull-up enables and offset 0x10 the pull-down enables. A 1 enables the resistor. A write to one of them clears the other's bits where the written value has 1s, so `pin_pu & pin_pd` is never nonzero.
- R10: Offset 0x14 holds the input enables. They read back as written and appear on `pin_ie`.
- R11: Reads of offset 0x08 and of unmapped offsets return 0. Writes to unmapped offsets change no state. `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address (word aligned) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| pready | output | 1 | Always 1 (zero wait states) |
| pin_in | input | 8 | Pad input values |
| pin_func | output | 32 | Per-pin 4-bit function codes |
| pin_out | output | 8 | Output values to pads |
| pin_oe | output | 8 | Pin is GPIO output |
| pin_pu | output | 8 | Pull-up enables |
| pin_pd | output | 8 | Pull-down enables |
| pin_ie | output | 8 | Input path enables |

## Verification
The bench mixes output pins, input pins and alternate-function pins inside one port. A design that applied set or clear to every pin would corrupt the non-output bits, and a design that read the output register for input pins would return stale values on data reads. The toggle and no-op encodings of the control word are driven separately from single set and single clear. A design that gave set priority over clear would miss the inversion. Pull writes overlap bits that are already enabled in the opposite register, which exposes a design that kept both enables or cleared the wrong side. Input reads are taken with the enables first off and then on.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NREG      = 6;
  localparam int unsigned IDX_FUNC  = 0;
  localparam int unsigned IDX_DATA  = 1;
  localparam int unsigned IDX_CTL   = 2;
  localparam int unsigned IDX_PU    = 3;
  localparam int unsigned IDX_PD    = 4;
  localparam int unsigned IDX_IE    = 5;
  localparam logic [3:0]  CODE_IN   = 4'b0000;
  localparam logic [3:0]  CODE_OUT  = 4'b0001;
endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   wr
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              wr_phase;

  assign widx     = paddr[ADDR_W-1:2];
  assign wr_phase = psel & penable & pwrite;

  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign hit[r] = (widx == WIDX_W'(r));
    assign wr[r]  = hit[r] & wr_phase;
  end
endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_data,
  input  logic            wr_ctl,
  input  logic [PINS-1:0] wdata_lo,
  input  logic [PINS-1:0] set_bits,
  input  logic [PINS-1:0] clr_bits,
  input  logic [PINS-1:0] is_out,
  output logic [PINS-1:0] out_val
);
  logic [PINS-1:0] ctl_next;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      ctl_next[i] = out_val[i];
      if (is_out[i]) begin
        case ({set_bits[i], clr_bits[i]})
          2'b10:   ctl_next[i] = 1'b1;
          2'b01:   ctl_next[i] = 1'b0;
          2'b11:   ctl_next[i] = ~out_val[i];
          default: ctl_next[i] = out_val[i];
        endcase
      end
    end

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && is_out[i] && set_bits[i] && !clr_bits[i]) |=> out_val[i]);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && is_out[i] && set_bits[i] && clr_bits[i]) |=> (out_val[i] != $past(out_val[i])));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !is_out[i]) |=> $stable(out_val[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_val <= '0;
    else if (wr_data) out_val <= wdata_lo;
    else if (wr_ctl)  out_val <= ctl_next;
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_pu,
  input  logic            wr_pd,
  input  logic            wr_ie,
  input  logic [PINS-1:0] wdata_lo,
  output logic [PINS-1:0] pu_en,
  output logic [PINS-1:0] pd_en,
  output logic [PINS-1:0] in_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_en <= '0;
      pd_en <= '0;
    end else if (wr_pu) begin
      pu_en <= wdata_lo;
      pd_en <= pd_en & ~wdata_lo;
    end else if (wr_pd) begin
      pd_en <= wdata_lo;
      pu_en <= pu_en & ~wdata_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_en <= '0;
    else if (wr_ie) in_en <= wdata_lo;
  end

  p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0);
  p_pu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pu |=> (pu_en == $past(wdata_lo)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned FUNC_W = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   pclk,
  input  logic                   presetn,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [DATA_W-1:0]      pwdata,
  output logic [DATA_W-1:0]      prdata,
  output logic                   pready,
  input  logic [PINS-1:0]        pin_in,
  output logic [PINS*FUNC_W-1:0] pin_func,
  output logic [PINS-1:0]        pin_out,
  output logic [PINS-1:0]        pin_oe,
  output logic [PINS-1:0]        pin_pu,
  output logic [PINS-1:0]        pin_pd,
  output logic [PINS-1:0]        pin_ie
);
  localparam int unsigned CFG_W = PINS * FUNC_W;

  logic [NREG-1:0]  hit, wr;
  logic [CFG_W-1:0] func_cfg;
  logic [PINS-1:0]  data_rd;

  assign pready = 1'b1;

  gpio_apb_decode #(.ADDR_W(ADDR_W)) i_decode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .hit(hit), .wr(wr)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)          func_cfg <= '0;
    else if (wr[IDX_FUNC]) func_cfg <= pwdata[CFG_W-1:0];
  end

  for (genvar i = 0; i < PINS; i++) begin : g_oe
    assign pin_oe[i]  = (func_cfg[i*FUNC_W +: FUNC_W] == FUNC_W'(CODE_OUT));
    assign data_rd[i] = pin_oe[i] ? pin_out[i] : (pin_in[i] & pin_ie[i]);
  end

  gpio_out_ctl #(.PINS(PINS)) i_out_ctl (
    .clk(pclk), .rst_n(presetn),
    .wr_data(wr[IDX_DATA]), .wr_ctl(wr[IDX_CTL]),
    .wdata_lo(pwdata[PINS-1:0]),
    .set_bits(pwdata[PINS-1:0]), .clr_bits(pwdata[2*PINS-1:PINS]),
    .is_out(pin_oe), .out_val(pin_out)
  );

  gpio_pad_ctl #(.PINS(PINS)) i_pad_ctl (
    .clk(pclk), .rst_n(presetn),
    .wr_pu(wr[IDX_PU]), .wr_pd(wr[IDX_PD]), .wr_ie(wr[IDX_IE]),
    .wdata_lo(pwdata[PINS-1:0]),
    .pu_en(pin_pu), .pd_en(pin_pd), .in_en(pin_ie)
  );

  assign pin_func = func_cfg;

  always_comb begin
    prdata = '0;
    if (hit[IDX_FUNC])      prdata[CFG_W-1:0] = func_cfg;
    else if (hit[IDX_DATA]) prdata[PINS-1:0]  = data_rd;
    else if (hit[IDX_PU])   prdata[PINS-1:0]  = pin_pu;
    else if (hit[IDX_PD])   prdata[PINS-1:0]  = pin_pd;
    else if (hit[IDX_IE])   prdata[PINS-1:0]  = pin_ie;
  end

  p_oe_code_r3: assert property (@(posedge pclk) disable iff (!presetn)
    wr[IDX_FUNC] |=> (pin_oe[0] == ($past(pwdata[FUNC_W-1:0]) == FUNC_W'(CODE_OUT))));
  p_func_load_r2: assert property (@(posedge pclk) disable iff (!presetn)
    wr[IDX_FUNC] |=> (pin_func == $past(pwdata[CFG_W-1:0])));
  p_data_load_r4: assert property (@(posedge pclk) disable iff (!presetn)
    wr[IDX_DATA] |=> (pin_out == $past(pwdata[PINS-1:0])));
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  pin_in = '0;
  logic [31:0] pin_func;
  logic [7:0]  pin_out, pin_oe, pin_pu, pin_pd, pin_ie;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_port_regs i_gpio_port_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pin_in(pin_in), .pin_func(pin_func), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_ie(pin_ie)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_func", 32'(pin_func), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pulls", {16'h0, pin_pu, pin_pd}, 0);
    chk("R1 pin_ie", 32'(pin_ie), 0);
    apb_rd(8'h00, d); chk("R1 func read", d, 0);
    chk("R11 pready", 32'(pready), 1);
  endtask

  task automatic t_func;
    logic [31:0] d;
    apb_wr(8'h00, 32'h3210_1F01);
    apb_rd(8'h00, d); chk("R2 func readback", d, 32'h3210_1F01);
    chk("R2 pin_func", pin_func, 32'h3210_1F01);
    chk("R3 pin_oe mixed codes", 32'(pin_oe), 32'h29);
  endtask

  task automatic t_data;
    logic [31:0] d;
    apb_wr(8'h04, 32'h0000_00A5);
    chk("R4 pin_out", 32'(pin_out), 32'hA5);
    pin_in = 8'h5A;
    apb_rd(8'h04, d); chk("R5 read ie off", d, 32'h21);
    apb_wr(8'h14, 32'hFF);
    apb_rd(8'h14, d); chk("R10 ie readback", d, 32'hFF);
    chk("R10 pin_ie", 32'(pin_ie), 32'hFF);
    apb_rd(8'h04, d); chk("R5 read ie on", d, 32'h73);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    apb_wr(8'h00, 32'h1111_1111);
    chk("R3 all output", 32'(pin_oe), 32'hFF);
    apb_wr(8'h08, 32'h0000_A00A);
    chk("R6 set/clear", 32'(pin_out), 32'h0F);
    apb_rd(8'h08, d); chk("R11 ctl reads 0", d, 0);
  endtask

  task automatic t_toggle;
    apb_wr(8'h08, 32'h0000_3333);
    chk("R7 toggle", 32'(pin_out), 32'h3C);
    apb_wr(8'h08, 32'h0);
    chk("R7 no-op", 32'(pin_out), 32'h3C);
  endtask

  task automatic t_nonout;
    apb_wr(8'h00, 32'h0000_0011);
    apb_wr(8'h08, 32'h0000_00FF);
    chk("R8 set only outputs", 32'(pin_out), 32'h3F);
    apb_wr(8'h08, 32'h0000_FF00);
    chk("R8 clear only outputs", 32'(pin_out), 32'h3C);
  endtask

  task automatic t_pulls;
    logic [31:0] d;
    apb_wr(8'h0C, 32'h0F);
    chk("R9 pu", {pin_pu, pin_pd}, 16'h0F00);
    apb_wr(8'h10, 32'h3C);
    chk("R9 pd wins", {pin_pu, pin_pd}, 16'h033C);
    apb_wr(8'h0C, 32'hF0);
    chk("R9 pu wins", {pin_pu, pin_pd}, 16'hF00C);
    apb_rd(8'h0C, d); chk("R9 pu read", d, 32'hF0);
    apb_rd(8'h10, d); chk("R9 pd read", d, 32'h0C);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    apb_wr(8'h18, 32'hFFFF_FFFF);
    apb_wr(8'h40, 32'hFFFF_FFFF);
    apb_rd(8'h18, d); chk("R11 unmapped read", d, 0);
    apb_rd(8'h00, d); chk("R11 func untouched", d, 32'h0000_0011);
    chk("R11 state untouched", {pin_out, pin_pu, pin_pd, pin_ie}, 32'h3CF00CFF);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_func();
    t_data();
    t_setclr();
    t_toggle();
    t_nonout();
    t_pulls();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule